// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns 32-bit words from a show-ahead sample FIFO into a two-channel serial audio stream. It puts out a bit clock, a frame clock that marks the left and right channel, and one serial data line. Data goes out MSB first. Each channel gets a fixed number of bit slots, and the slots after the sample carry zeros. The framing is set by a few static controls: a one-slot data delay, which gives I2S framing when set and left-justified framing when clear; the frame clock level that marks the left channel; the bit clock edge on which data changes; and a word length code.

In master mode the block divides its system clock to make the bit clock and counts slots to make the frame clock. In slave mode it takes both clocks from another port, synchronises them into its own clock domain and lines up on the frame clock transition into the left channel. When a sample is due and the FIFO is empty, the block sends silence and flags the miss with a one-cycle pulse. When the run control is dropped, the block completes the frame in progress and then goes quiet.

Top module: `audio_ser_tx`

## Requirements
- R1: After reset, `bclk_o`, `fsclk_o`, `sdata_o`, `underflow_o` and `fifo_pop` are all 0. They stay 0 while `cfg_run` is 0, even when the FIFO holds data.
- R2: In master mode one bit clock period lasts 2*DIV_HALF system cycles. Each channel lasts 16 bit periods for word length code 0 and 24 bit periods for codes 4 and 8, so a frame is 32 or 48 bit clocks long.
- R3: With `cfg_delay`=1 the sample MSB goes out one bit slot after the frame clock changes to that channel. With `cfg_delay`=0 the MSB goes out in the same slot as the change.
- R4: The frame clock level during the left channel equals `cfg_fs_pol`. The right channel uses the inverse level. Frames begin with the left channel.
- R5: With `cfg_edge`=0, data and the frame clock change on the falling edge of `bclk_o`. With `cfg_edge`=1 they change on the rising edge. `sdata_o` never changes between two such launch edges.
- R6: Word length code 0 (16 bit) takes one FIFO word per frame, with the left sample in bits [15:0] and the right sample in bits [31:16]. Code 4 (20 bit) and code 8 (24 bit) take one FIFO word per channel, left first, with the sample in bits [19:0] or [23:0]. Any other code behaves as code 0.
- R7: Samples are sent MSB first, and every slot after the last sample bit carries 0.
- R8: If the FIFO is empty when a word is needed, that word's sample slots carry zeros (in 16-bit mode both channels of the frame), no word is popped, and `underflow_o` is high for exactly one system cycle.
- R9: When `cfg_run` is cleared, the frame in progress completes. At the next frame boundary `bclk_o`, `fsclk_o` and `sdata_o` return to 0 and no further words are popped.
- R10: With `cfg_slave`=1, bit timing comes from `ext_bclk` and channel timing from `ext_fsclk`. Output starts at the first frame clock transition into the left level seen while `cfg_run` is 1, and `bclk_o` and `fsclk_o` stay 0.
- R11: `fifo_pop` is a single-cycle pulse, raised exactly once for each word taken while the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run | input | 1 | Start streaming; clear to stop at the frame end |
| cfg_slave | input | 1 | 1: use external bit and frame clocks |
| cfg_delay | input | 1 | 1: MSB one slot after the frame clock change (I2S) |
| cfg_fs_pol | input | 1 | Frame clock level that marks the left channel |
| cfg_edge | input | 1 | 0: data changes on falling bit clock edge; 1: rising |
| cfg_wlen | input | 4 | Word length code: 0=16, 4=20, 8=24 bits |
| fifo_data | input | 32 | Head word of the sample FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Consume the head word this cycle |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fsclk | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock |
| fsclk_o | output | 1 | Generated frame clock |
| sdata_o | output | 1 | Serial data |
| underflow_o | output | 1 | One-cycle pulse on a missed sample |

## Verification
The assertions rely on three conditions. The configuration inputs change only while the port is idle and `cfg_run` is low. In slave mode each level of the external bit clock lasts at least two system cycles. `fifo_data` is valid whenever `fifo_empty` is low. The stimulus changes configuration only between scenarios, after the output has gone idle. It drives the external clocks with eight-cycle levels and moves the external frame clock only together with the bit clock's launch edge. The FIFO model presents its head word combinationally and advances on each pop.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  localparam int unsigned FIFO_DW  = 32;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned SLOT_W   = 5;

  typedef enum logic [3:0] {
    WLEN_16 = 4'd0,
    WLEN_20 = 4'd4,
    WLEN_24 = 4'd8
  } wlen_e;

  function automatic logic wlen_is_wide(input logic [3:0] code);
    return (code == WLEN_20) || (code == WLEN_24);
  endfunction

  function automatic logic [SLOT_W-1:0] wlen_slots(input logic [3:0] code);
    return wlen_is_wide(code) ? SLOT_W'(24) : SLOT_W'(16);
  endfunction

  // Left-align the sample field of a FIFO word into the shift register width
  function automatic logic [SAMPLE_W-1:0] wlen_align(input logic [FIFO_DW-1:0] d,
                                                     input logic [3:0] code);
    case (code)
      WLEN_20: return {d[19:0], 4'b0};
      WLEN_24: return d[23:0];
      default: return {d[15:0], 8'b0};
    endcase
  endfunction

endpackage

// File: rtl/atx_bitclk.sv
module atx_bitclk #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slave,
  input  logic edge_sel,
  input  logic enable,
  input  logic ext_bclk,
  input  logic ext_fs,
  output logic tick,
  output logic raw_bclk,
  output logic fs_sync
);

  localparam int unsigned PERIOD = 2 * DIV_HALF;
  localparam int unsigned CNT_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             raw_q, raw_d;
  logic [2:0]       bsync_q;
  logic [1:0]       fsync_q;
  logic             master_tick, slave_tick, run_div;

  assign run_div     = enable && !slave;
  assign master_tick = run_div && (cnt_q == CNT_W'(PERIOD - 1));
  assign slave_tick  = slave && (edge_sel ? (bsync_q[1] && !bsync_q[2])
                                          : (!bsync_q[1] && bsync_q[2]));
  assign tick        = master_tick || slave_tick;
  assign raw_bclk    = raw_q;
  assign fs_sync     = fsync_q[1];

  always_comb begin
    cnt_d = cnt_q;
    raw_d = raw_q;
    if (!run_div) begin
      cnt_d = '0;
      raw_d = 1'b0;
    end else if (master_tick) begin
      cnt_d = '0;
      raw_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(DIV_HALF - 1)) raw_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      raw_q   <= 1'b0;
      bsync_q <= '0;
      fsync_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      raw_q   <= raw_d;
      bsync_q <= {bsync_q[1:0], ext_bclk};
      fsync_q <= {fsync_q[0], ext_fs};
    end
  end

endmodule

// File: rtl/atx_framer.sv
module atx_framer
  import audio_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slave,
  input  logic       run,
  input  logic       delay,
  input  logic       pol,
  input  logic [3:0] wlen,
  input  logic       tick,
  input  logic       fs_in,
  output logic       shift,
  output logic       load,
  output logic       load_ch,
  output logic       clear,
  output logic       active,
  output logic       fs_out
);

  logic              active_q, active_d;
  logic [SLOT_W-1:0] slot_q, slot_d, last_slot;
  logic              ch_q, ch_d, seen_q, seen_d, fs_q, fs_d, ch_in;

  assign last_slot = wlen_slots(wlen) - 1'b1;
  assign ch_in     = fs_in ^ pol;

  always_comb begin
    active_d = active_q;
    slot_d   = slot_q;
    ch_d     = ch_q;
    seen_d   = seen_q;
    if (tick) begin
      if (slave) seen_d = ch_in;
      if (!active_q) begin
        if (run && (!slave || (!ch_in && seen_q))) begin
          active_d = 1'b1;
          slot_d   = '0;
          ch_d     = 1'b0;
        end
      end else begin
        if (slave) begin
          ch_d   = ch_in;
          slot_d = (ch_in != ch_q) ? '0 :
                   ((slot_q == '1) ? slot_q : slot_q + 1'b1);
        end else if (slot_q == last_slot) begin
          slot_d = '0;
          ch_d   = !ch_q;
        end else begin
          slot_d = slot_q + 1'b1;
        end
        if ((slot_d == '0) && !ch_d && ch_q && !run) active_d = 1'b0;
      end
    end
    fs_d = tick ? ((active_d && !slave) ? (ch_d ^ pol) : 1'b0) : fs_q;
  end

  assign shift   = tick && active_d;
  assign load    = shift && (slot_d == {{(SLOT_W-1){1'b0}}, delay});
  assign load_ch = ch_d;
  assign clear   = tick && !active_d;
  assign active  = active_q;
  assign fs_out  = fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      ch_q     <= 1'b0;
      seen_q   <= 1'b0;
      fs_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      slot_q   <= slot_d;
      ch_q     <= ch_d;
      seen_q   <= seen_d;
      fs_q     <= fs_d;
    end
  end

  AST_FS_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(fs_q)); // R5
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !slave) |-> (slot_q <= last_slot)); // R2
  AST_IDLE_FS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !fs_q); // R9

endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
  import audio_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         wlen,
  input  logic               shift,
  input  logic               load,
  input  logic               load_ch,
  input  logic               clear,
  input  logic [FIFO_DW-1:0] fifo_data,
  input  logic               fifo_empty,
  output logic               fifo_pop,
  output logic               sdata,
  output logic               underflow
);

  localparam int unsigned HALF_W = FIFO_DW / 2;
  localparam int unsigned PAD_W  = SAMPLE_W - HALF_W;

  logic [SAMPLE_W-1:0] sh_q, sh_d, word;
  logic [HALF_W-1:0]   hold_q, hold_d;
  logic                sd_q, sd_d, uf_q, uf_d;
  logic                wide, need_fifo;

  assign wide      = wlen_is_wide(wlen);
  assign need_fifo = load && (wide || !load_ch);
  assign fifo_pop  = need_fifo && !fifo_empty;
  assign uf_d      = need_fifo && fifo_empty;

  always_comb begin
    if (need_fifo) word = fifo_empty ? '0 : wlen_align(fifo_data, wlen);
    else           word = {hold_q, {PAD_W{1'b0}}};
  end

  always_comb begin
    hold_d = hold_q;
    if (need_fifo && !wide) hold_d = fifo_empty ? '0 : fifo_data[FIFO_DW-1:HALF_W];
  end

  always_comb begin
    sd_d = sd_q;
    sh_d = sh_q;
    if (load) begin
      sd_d = word[SAMPLE_W-1];
      sh_d = {word[SAMPLE_W-2:0], 1'b0};
    end else if (shift) begin
      sd_d = sh_q[SAMPLE_W-1];
      sh_d = {sh_q[SAMPLE_W-2:0], 1'b0};
    end else if (clear) begin
      sd_d = 1'b0;
      sh_d = '0;
    end
  end

  assign sdata     = sd_q;
  assign underflow = uf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hold_q <= '0;
      sd_q   <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      hold_q <= hold_d;
      sd_q   <= sd_d;
      uf_q   <= uf_d;
    end
  end

  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop); // R11
  AST_UFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow); // R8
  AST_SDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !clear) |=> $stable(sdata)); // R5

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_tx_pkg::*;
#(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_run,
  input  logic               cfg_slave,
  input  logic               cfg_delay,
  input  logic               cfg_fs_pol,
  input  logic               cfg_edge,
  input  logic [3:0]         cfg_wlen,
  input  logic [FIFO_DW-1:0] fifo_data,
  input  logic               fifo_empty,
  output logic               fifo_pop,
  input  logic               ext_bclk,
  input  logic               ext_fsclk,
  output logic               bclk_o,
  output logic               fsclk_o,
  output logic               sdata_o,
  output logic               underflow_o
);

  logic tick, raw_bclk, fs_sync;
  logic shift, load, load_ch, clear, active, fs_gen;

  atx_bitclk #(.DIV_HALF(DIV_HALF)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slave    (cfg_slave),
    .edge_sel (cfg_edge),
    .enable   (cfg_run || active),
    .ext_bclk (ext_bclk),
    .ext_fs   (ext_fsclk),
    .tick     (tick),
    .raw_bclk (raw_bclk),
    .fs_sync  (fs_sync)
  );

  atx_framer u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .slave   (cfg_slave),
    .run     (cfg_run),
    .delay   (cfg_delay),
    .pol     (cfg_fs_pol),
    .wlen    (cfg_wlen),
    .tick    (tick),
    .fs_in   (fs_sync),
    .shift   (shift),
    .load    (load),
    .load_ch (load_ch),
    .clear   (clear),
    .active  (active),
    .fs_out  (fs_gen)
  );

  atx_shifter u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .wlen       (cfg_wlen),
    .shift      (shift),
    .load       (load),
    .load_ch    (load_ch),
    .clear      (clear),
    .fifo_data  (fifo_data),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .sdata      (sdata_o),
    .underflow  (underflow_o)
  );

  assign bclk_o  = (active && !cfg_slave) ? (raw_bclk ^ cfg_edge) : 1'b0;
  assign fsclk_o = fs_gen;

endmodule

// File: tb/test_audio_ser_tx.sv
`timescale 1ns/1ps
module test_audio_ser_tx;

  localparam int unsigned DIVH = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_run, cfg_slave, cfg_delay, cfg_fs_pol, cfg_edge;
  logic [3:0] cfg_wlen;
  logic [31:0] fifo_data;
  logic fifo_empty, fifo_pop;
  logic ext_bclk, ext_fsclk;
  logic bclk_o, fsclk_o, sdata_o, underflow_o;

  always #4 clk = ~clk;

  logic [31:0] mem [8];
  int wr_n, rd;
  logic fifo_clr;
  assign fifo_data  = mem[rd[2:0]];
  assign fifo_empty = (rd >= wr_n);
  always @(posedge clk) begin
    if (fifo_clr) rd <= 0;
    else if (fifo_pop) rd <= rd + 1;
  end

  audio_ser_tx #(.DIV_HALF(DIVH)) i_audio_ser_tx (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_slave(cfg_slave),
    .cfg_delay(cfg_delay), .cfg_fs_pol(cfg_fs_pol), .cfg_edge(cfg_edge),
    .cfg_wlen(cfg_wlen), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .ext_bclk(ext_bclk), .ext_fsclk(ext_fsclk),
    .bclk_o(bclk_o), .fsclk_o(fsclk_o), .sdata_o(sdata_o),
    .underflow_o(underflow_o)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor of the master-mode stream
  logic cap_sd [256];
  logic cap_fs [256];
  logic exp_sd [256];
  int cap_n, cap_tot, bad_edge, bad_per, n_uf, slave_nz, cyc, last_cap;
  bit mon_on = 0;
  logic prev_b = 1'b0, prev_sd = 1'b0;

  always @(negedge clk) begin
    logic launch, captr;
    cyc++;
    if (underflow_o) n_uf++;
    if (cfg_slave && (bclk_o || fsclk_o)) slave_nz++;
    if (mon_on) begin
      launch = cfg_edge ? (!prev_b && bclk_o) : (prev_b && !bclk_o);
      captr  = cfg_edge ? (prev_b && !bclk_o) : (!prev_b && bclk_o);
      if ((sdata_o != prev_sd) && !launch && cap_n > 0 && cap_n < cap_tot) bad_edge++;
      if (captr) begin
        if (cap_n < 256) begin
          cap_sd[cap_n] = sdata_o;
          cap_fs[cap_n] = fsclk_o;
        end
        if (cap_n > 0 && (cyc - last_cap) != 2 * DIVH) bad_per++;
        last_cap = cyc;
        cap_n++;
      end
    end
    prev_b  = bclk_o;
    prev_sd = sdata_o;
  end

  task automatic fill_fifo(input int nw, input logic [31:0] seed);
    for (int i = 0; i < 8; i++) mem[i] = seed ^ (32'h9E37_79B9 * (i + 1));
    wr_n = nw;
    @(negedge clk); fifo_clr = 1'b1;
    @(negedge clk); fifo_clr = 1'b0;
  endtask

  task automatic build_exp(input bit dly, input logic [3:0] wl, input int nw,
                           input int nf, input int total);
    bit wide;
    int S, W;
    wide = (wl == 4'd4) || (wl == 4'd8);
    S = wide ? 24 : 16;
    W = (wl == 4'd4) ? 20 : ((wl == 4'd8) ? 24 : 16);
    for (int i = 0; i < 256; i++) exp_sd[i] = 1'b0;
    for (int c = 0; c < 2 * nf; c++) begin
      logic [31:0] smp;
      int wd;
      wd = wide ? c : c / 2;
      smp = (wd < nw) ? mem[wd] : 32'h0;
      if (!wide) smp = (c % 2 == 1) ? (smp >> 16) : (smp & 32'hFFFF);
      for (int j = 0; j < W; j++) begin
        int p;
        p = c * S + int'(dly) + j;
        if (p < total && p < 256) exp_sd[p] = smp[W-1-j];
      end
    end
  endtask

  task automatic test_reset();
    wr_n = 2;
    repeat (20) @(negedge clk);
    chk(!bclk_o && !fsclk_o && !sdata_o, "R1 outputs low after reset", {bclk_o, fsclk_o, sdata_o}, 0);
    chk(!underflow_o && !fifo_pop, "R1 no pop or underflow while idle", {underflow_o, fifo_pop}, 0);
    chk(rd == 0, "R1 FIFO untouched while run low", rd, 0);
  endtask

  task automatic run_master(input string nm, input bit dly, input bit pol, input bit edg,
                            input logic [3:0] wl, input int nw, input int nf);
    bit wide;
    int S, total, need, pops, dmis, fmis, last;
    wide = (wl == 4'd4) || (wl == 4'd8);
    S = wide ? 24 : 16;
    total = 2 * S * nf;
    need = wide ? 2 * nf : nf;
    pops = (nw < need) ? nw : need;
    cfg_slave = 0; cfg_delay = dly; cfg_fs_pol = pol; cfg_edge = edg; cfg_wlen = wl;
    fill_fifo(nw, 32'hC0DE_0000 + {24'h0, wl, 1'b0, dly, pol, edg});
    @(negedge clk);
    prev_b = bclk_o; prev_sd = sdata_o;
    cap_n = 0; cap_tot = total; bad_edge = 0; bad_per = 0; n_uf = 0;
    mon_on = 1;
    cfg_run = 1;
    for (int k = 0; k < 20000 && cap_n < total - S / 2; k++) @(negedge clk);
    cfg_run = 0;
    for (int k = 0; k < 50; k++) begin
      last = cap_n;
      repeat (40) @(negedge clk);
      if (cap_n == last) break;
    end
    mon_on = 0;
    build_exp(dly, wl, nw, nf, total);
    dmis = 0; fmis = 0;
    for (int i = 0; i < total && i < 256; i++) begin
      if (cap_sd[i] != exp_sd[i]) dmis++;
      if (cap_fs[i] != (((i / S) % 2 == 1) ^ pol)) fmis++;
    end
    $display("[TB] %s", nm);
    chk(cap_n == total, "R9 frame completes then bit clock stops", cap_n, total);
    chk(dmis == 0, "R3 R6 R7 serial data stream", dmis, 0);
    chk(fmis == 0, "R4 frame clock level per channel", fmis, 0);
    chk(bad_per == 0, "R2 bit clock period", bad_per, 0);
    chk(bad_edge == 0, "R5 data changes only on launch edge", bad_edge, 0);
    chk(n_uf == need - pops, "R8 underflow pulses", n_uf, need - pops);
    chk(rd == pops, "R11 words popped", rd, pops);
    chk(!bclk_o && !fsclk_o && !sdata_o, "R9 outputs low after stop", {bclk_o, fsclk_o, sdata_o}, 0);
  endtask

  task automatic run_slave(input int nf);
    int S, total, dmis, tail_bad, uf_before;
    S = 16;
    total = 2 * S * nf;
    cfg_slave = 1; cfg_delay = 1; cfg_fs_pol = 0; cfg_edge = 0; cfg_wlen = 4'd0;
    fill_fifo(nf, 32'h5A5A_1234);
    ext_bclk = 1; ext_fsclk = 1;
    slave_nz = 0; n_uf = 0;
    repeat (10) @(negedge clk);
    cfg_run = 1;
    for (int i = 0; i < S; i++) begin
      ext_bclk = 0; ext_fsclk = 1;
      repeat (8) @(negedge clk);
      ext_bclk = 1;
      repeat (8) @(negedge clk);
    end
    for (int i = 0; i < total; i++) begin
      if (i == total - S / 2) cfg_run = 0;
      ext_bclk = 0; ext_fsclk = ((i / S) % 2 == 1);
      repeat (8) @(negedge clk);
      cap_sd[i] = sdata_o;
      ext_bclk = 1;
      repeat (8) @(negedge clk);
    end
    uf_before = n_uf;
    tail_bad = 0;
    for (int i = 0; i < 6; i++) begin
      ext_bclk = 0; ext_fsclk = 0;
      repeat (8) @(negedge clk);
      if (sdata_o) tail_bad++;
      ext_bclk = 1;
      repeat (8) @(negedge clk);
    end
    build_exp(1'b1, 4'd0, nf, nf, total);
    dmis = 0;
    for (int i = 0; i < total; i++) if (cap_sd[i] != exp_sd[i]) dmis++;
    $display("[TB] slave I2S 16-bit");
    chk(dmis == 0, "R10 slave data follows external clocks", dmis, 0);
    chk(slave_nz == 0, "R10 clock outputs held low in slave mode", slave_nz, 0);
    chk(tail_bad == 0, "R9 slave data low after stop", tail_bad, 0);
    chk(rd == nf && uf_before == 0, "R11 slave pops one word per frame", rd, nf);
    cfg_slave = 0;
  endtask

  initial begin
    rst_n = 0; cfg_run = 0; cfg_slave = 0; cfg_delay = 0; cfg_fs_pol = 0;
    cfg_edge = 0; cfg_wlen = 4'd0; ext_bclk = 0; ext_fsclk = 0;
    fifo_clr = 1; wr_n = 0;
    for (int i = 0; i < 8; i++) mem[i] = 32'h0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk); fifo_clr = 0;
    test_reset();
    run_master("I2S 16-bit, left low, falling launch", 1, 0, 0, 4'd0, 2, 2);
    run_master("left-justified 16-bit, left high, rising launch", 0, 1, 1, 4'd0, 2, 2);
    run_master("I2S 24-bit, two words per frame", 1, 0, 1, 4'd8, 4, 2);
    run_master("left-justified 20-bit, FIFO runs dry", 0, 0, 0, 4'd4, 3, 2);
    run_master("I2S 16-bit, empty FIFO for two frames", 1, 1, 0, 4'd0, 1, 3);
    run_slave(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule